// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps the data of one DRAM bank alive. Cell charge leaks, so each row must be rewritten within a retention window. The block does this by restoring rows one at a time. Each row restore is an activate of the row, then a precharge after a fixed row-active time. A mode pin chooses between two schedules. In the spread schedule, a single row falls due every `PERIOD_CYC / ROWS` cycles, so the bank is never out of service for long. In the block schedule, every row falls due together once per retention window and the rows are restored one after another.

Due rows are recorded in an owed-row counter. While rows are owed and no restore is running, the block holds a request towards the bank arbiter. The request works like a valid/ready pair with back-pressure. The request (valid) stays high until the arbiter answers with a grant (ready) in the same cycle. Each grant starts exactly one row restore. No owed row is ever discarded. Whenever the timer expires while earlier rows are still waiting, a saturating postponement counter is bumped. While a restore runs, a busy output tells the access path to keep away from the bank.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ref_req`, `bank_busy`, `ref_act` and `ref_pre` are 0, and `ref_row` and `postponed` are 0. The interval timer comes out of reset at zero, so its first expiry happens on the first rising edge with `rst_n` high.
- R2: With `burst_mode` = 0 at an expiry, the timer reloads to `PERIOD_CYC/ROWS - 1` and one row is added to the owed count. With a permanent grant, successive activates are therefore exactly `PERIOD_CYC/ROWS` cycles apart.
- R3: With `burst_mode` = 1 at an expiry, the timer reloads to `PERIOD_CYC - 1` and `ROWS` rows are added to the owed count. These rows are restored back to back, each after its own grant.
- R4: `ref_req` is 1 exactly when no restore is running and the owed count is non-zero. A grant is acted on only in a cycle where `ref_req` is 1; at any other time `ref_gnt` has no effect on any output.
- R5: A grant sampled on an edge makes `ref_act` a one-cycle pulse in the next cycle. `ref_pre` pulses exactly `TRAS_CYC` cycles after `ref_act`. `ref_row` gives the row being restored during both pulses.
- R6: `bank_busy` is 1 from the `ref_act` cycle through the `TRP_CYC - 1` cycles after `ref_pre`, `TRAS_CYC + TRP_CYC` cycles in all, and 0 otherwise.
- R7: `ref_row` advances by one after each `ref_pre` and otherwise holds. After row `ROWS - 1` it wraps to 0.
- R8: Owed rows are never dropped. Every row added by R2 or R3 is eventually granted and restored, however long the grant is withheld (within the owed counter's range).
- R9: `postponed` increments by one on each timer expiry at which the owed count is already non-zero. It stays at all-ones once it reaches all-ones, and otherwise holds.
- R10: `burst_mode` is sampled only at a timer expiry. It picks both the reload value and the number of rows added at that expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | 1 = all rows once per window, 0 = one row per slot |
| ref_gnt | input | 1 | Arbiter grant (ready) for the refresh request |
| ref_req | output | 1 | Refresh request (valid) towards the bank arbiter |
| bank_busy | output | 1 | Bank occupied by a row restore; normal accesses must wait |
| ref_act | output | 1 | One-cycle activate command for `ref_row` |
| ref_pre | output | 1 | One-cycle precharge command for `ref_row` |
| ref_row | output | $clog2(ROWS) | Row currently being restored |
| postponed | output | PCNT_W | Saturating count of expiries that found rows still owed |

## Verification
The assertions assume that `PERIOD_CYC/ROWS` is larger than one full restore (`TRAS_CYC + TRP_CYC` plus the handshake cycle) and that `TRAS_CYC` and `TRP_CYC` are at least 2. They also assume that the grant is never withheld long enough to push the owed counter past its range. The bench keeps to these limits with a slot of 20 cycles against a 7-cycle restore. It withholds the grant for only a few slots, and in block mode it gives the arbiter enough grants to finish all eight rows well inside one window.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACT,
    PH_RAS,
    PH_PRE,
    PH_RP
  } ref_phase_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned PERIOD_CYC = 16000000,
  parameter int unsigned ROWS       = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  output logic tick
);
  localparam int unsigned SLOT_CYC = PERIOD_CYC / ROWS;
  localparam int unsigned TMR_W    = $clog2(PERIOD_CYC);
  localparam logic [TMR_W-1:0] SLOT_LD  = TMR_W'(SLOT_CYC - 1);
  localparam logic [TMR_W-1:0] BURST_LD = TMR_W'(PERIOD_CYC - 1);

  logic [TMR_W-1:0] tmr_q;

  assign tick = (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmr_q <= '0;
    else if (tick) tmr_q <= burst_mode ? BURST_LD : SLOT_LD;
    else           tmr_q <= tmr_q - 1'b1;
  end

  a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q != '0) |=> (tmr_q == $past(tmr_q) - 1'b1));
  a_r10_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tmr_q == ($past(burst_mode) ? BURST_LD : SLOT_LD)));
endmodule

// File: rtl/ref_owed_tracker.sv
module ref_owed_tracker #(
  parameter int unsigned ROWS   = 16384,
  parameter int unsigned OWE_W  = 18,
  parameter int unsigned PCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              burst_mode,
  input  logic              take,
  output logic              pending,
  output logic [PCNT_W-1:0] postponed
);
  localparam logic [OWE_W-1:0] BURST_ADD = OWE_W'(ROWS);
  localparam logic [OWE_W-1:0] SLOT_ADD  = OWE_W'(1);

  logic [OWE_W-1:0] owed_q;
  logic [OWE_W-1:0] add_w;
  logic [OWE_W:0]   sum_w;
  logic [PCNT_W-1:0] post_q;

  always_comb begin
    add_w = tick ? (burst_mode ? BURST_ADD : SLOT_ADD) : '0;
    sum_w = {1'b0, owed_q} + {1'b0, add_w} - (OWE_W+1)'(take);
  end

  assign pending   = (owed_q != '0);
  assign postponed = post_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
      post_q <= '0;
    end else begin
      owed_q <= sum_w[OWE_W] ? '1 : sum_w[OWE_W-1:0];
      if (tick && pending && (post_q != '1)) post_q <= post_q + 1'b1;
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_w[OWE_W]);
  a_r8_take_needs_owed: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pending);
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(post_q));
endmodule

// File: rtl/ref_row_sequencer.sv
module ref_row_sequencer
  import dram_ref_pkg::*;
#(
  parameter int unsigned ROWS     = 16384,
  parameter int unsigned TRAS_CYC = 10,
  parameter int unsigned TRP_CYC  = 4,
  parameter int unsigned ROW_W    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             act,
  output logic             pre,
  output logic [ROW_W-1:0] row
);
  localparam int unsigned MAXW   = (TRAS_CYC > TRP_CYC) ? TRAS_CYC : TRP_CYC;
  localparam int unsigned WAIT_W = $clog2(MAXW + 1);
  localparam logic [WAIT_W-1:0] RAS_LD = WAIT_W'(TRAS_CYC - 2);
  localparam logic [WAIT_W-1:0] RP_LD  = WAIT_W'(TRP_CYC - 2);
  localparam logic [ROW_W-1:0]  LAST_ROW = ROW_W'(ROWS - 1);

  ref_phase_e        ph_q;
  logic [WAIT_W-1:0] wait_q;
  logic [ROW_W-1:0]  row_q;

  assign busy = (ph_q != PH_IDLE);
  assign act  = (ph_q == PH_ACT);
  assign pre  = (ph_q == PH_PRE);
  assign row  = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      wait_q <= '0;
      row_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start) ph_q <= PH_ACT;
        PH_ACT: begin
          ph_q   <= PH_RAS;
          wait_q <= RAS_LD;
        end
        PH_RAS: begin
          if (wait_q == '0) ph_q <= PH_PRE;
          else              wait_q <= wait_q - 1'b1;
        end
        PH_PRE: begin
          ph_q   <= PH_RP;
          wait_q <= RP_LD;
          row_q  <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
        end
        PH_RP: begin
          if (wait_q == '0) ph_q <= PH_IDLE;
          else              wait_q <= wait_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  a_r5_act_single: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> !act);
  a_r5_start_gives_act: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> act);
  a_r6_cmd_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (act || pre) |-> busy);
  a_r7_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pre |=> $stable(row_q));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned PERIOD_CYC = 16000000,
  parameter int unsigned ROWS       = 16384,
  parameter int unsigned TRAS_CYC   = 10,
  parameter int unsigned TRP_CYC    = 4,
  parameter int unsigned PCNT_W     = 8,
  parameter int unsigned ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_mode,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              bank_busy,
  output logic              ref_act,
  output logic              ref_pre,
  output logic [ROW_W-1:0]  ref_row,
  output logic [PCNT_W-1:0] postponed
);
  localparam int unsigned OWE_W = ROW_W + 4;

  logic tick;
  logic pending;
  logic take;

  assign ref_req = pending && !bank_busy;
  assign take    = ref_req && ref_gnt;

  ref_interval_timer #(.PERIOD_CYC(PERIOD_CYC), .ROWS(ROWS)) u_timer (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .tick(tick)
  );

  ref_owed_tracker #(.ROWS(ROWS), .OWE_W(OWE_W), .PCNT_W(PCNT_W)) u_owed (
    .clk(clk), .rst_n(rst_n), .tick(tick), .burst_mode(burst_mode),
    .take(take), .pending(pending), .postponed(postponed)
  );

  ref_row_sequencer #(.ROWS(ROWS), .TRAS_CYC(TRAS_CYC), .TRP_CYC(TRP_CYC),
                      .ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(take), .busy(bank_busy),
    .act(ref_act), .pre(ref_pre), .row(ref_row)
  );

  a_r4_req_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !bank_busy);
  a_r4_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);
endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int PER  = 160;
  localparam int NR   = 8;
  localparam int TRAS = 4;
  localparam int TRP  = 3;
  localparam int SLOT = PER / NR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_mode = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, bank_busy, ref_act, ref_pre;
  logic [2:0] ref_row;
  logic [7:0] postponed;

  always #2 clk = ~clk;

  dram_refresh_sched #(.PERIOD_CYC(PER), .ROWS(NR), .TRAS_CYC(TRAS),
                       .TRP_CYC(TRP), .PCNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .bank_busy(bank_busy), .ref_act(ref_act),
    .ref_pre(ref_pre), .ref_row(ref_row), .postponed(postponed)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference: k = cycles since activate, -1 when idle
  int m_tmr = 0, m_owed = 0, m_post = 0, m_row = 0, m_k = -1;
  int m_added = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input int act_v, input int exp_v);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_tmr = 0; m_owed = 0; m_post = 0; m_row = 0; m_k = -1;
    end else begin
      bit tk, tk_take;
      tk = (m_tmr == 0);
      tk_take = (m_k < 0) && (m_owed > 0) && ref_gnt;   // R4
      // R2 R3 R10: mode read only at expiry
      if (tk) m_tmr = (burst_mode ? PER : SLOT) - 1;
      else    m_tmr = m_tmr - 1;
      if (tk && m_owed > 0 && m_post < 255) m_post++;   // R9
      if (tk) begin
        m_owed += burst_mode ? NR : 1;
        m_added += burst_mode ? NR : 1;
      end
      if (tk_take) m_owed--;
      if (m_k >= 0) begin
        if (m_k == TRAS) m_row = (m_row + 1) % NR;     // R7
        m_k++;
        if (m_k == TRAS + TRP) m_k = -1;
      end else if (tk_take) m_k = 0;
    end
  end

  // per-cycle comparison away from the active edge
  int acts_seen = 0, last_act = -1, burst_acts = 0;
  bit spacing_on = 0, saw_wrap = 0, in_burst = 0;
  int prev_act_row = -1;
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R4 R10 req", ref_req, (m_k < 0 && m_owed > 0));
      chk("R6 busy", bank_busy, (m_k >= 0));
      chk("R5 act", ref_act, (m_k == 0));
      chk("R5 pre", ref_pre, (m_k == TRAS));
      chk("R7 row", ref_row, m_row);
      chk("R9 postponed", postponed, m_post);
      if (ref_act) begin
        acts_seen++;
        if (in_burst) burst_acts++;
        if (spacing_on && last_act >= 0) chk("R2 slot spacing", cyc - last_act, SLOT);
        last_act = cyc;
        if (prev_act_row == NR - 1 && ref_row == 0) saw_wrap = 1;
        prev_act_row = ref_row;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired cyc=%0d actual=running expected=finished", cyc);
    finish_run();
  end

  initial begin
    ref_gnt = 1'b1;            // R4: grant with no request must do nothing
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req", ref_req, 0);
    chk("R1 busy", bank_busy, 0);
    chk("R1 act/pre", {ref_act, ref_pre}, 0);
    chk("R1 row", ref_row, 0);
    chk("R1 postponed", postponed, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    chk("R1 first expiry", ref_req, 1);
    // distributed mode, permanent grant
    spacing_on = 1;
    repeat (200) @(negedge clk);
    spacing_on = 0;
    // withhold grant across several slots
    ref_gnt = 1'b0;
    repeat (70) @(negedge clk);
    chk("R9 postponement seen", (postponed > 0), 1);
    chk("R8 request held", ref_req, 1);
    ref_gnt = 1'b1;
    repeat (200) @(negedge clk);
    chk("R8 owed drained", acts_seen, m_added - m_owed);
    // block mode with a sparse grant pattern
    burst_mode = 1'b1;
    in_burst = 1;
    for (int i = 0; i < 480; i++) begin
      ref_gnt = (i % 4 != 1);
      @(negedge clk);
    end
    in_burst = 0;
    chk("R3 back-to-back rows", (burst_acts >= NR), 1);
    burst_mode = 1'b0;
    ref_gnt = 1'b1;
    repeat (250) @(negedge clk);
    chk("R7 wrap to row 0", saw_wrap, 1);
    chk("R8 all owed served", acts_seen, m_added - m_owed);
    finish_run();
  end
endmodule